// File: doc/BRIEF.md
# SDRAM Open-Page Command Sequencer

This block turns single read or write requests, each carrying a bank, row and column, into a stream of abstract SDRAM commands. It remembers which row is open in each of four banks. Under the open-page policy a request to the row that is already open goes straight to a column command. A request to a closed bank gets an activate first. A request to a different row in an open bank gets a precharge, then an activate, then the column command. Under any other policy the column command carries auto-precharge, so the row closes once the access is done.

Commands leave through a valid/ready handshake. The sequencer holds three minimum spacings: precharge to activate, activate to column command, and activate to precharge. Each spacing is loaded from an input at the moment its wait starts. A refresh request closes all open rows with a precharge-all when needed, waits, and issues a refresh. Periodic refresh is how the system bounds how long any row stays active.

Top module: `sdram_page_seq`

## Requirements
- R1: After reset no bank holds an open row, `req_ready` is 1 and `cmd_valid` is 0.
- R2: With `policy_mode` = 0, a request whose row equals the open row of its bank produces exactly one command in the cycle after acceptance: READ (`cmd_op`=1) or WRIT (`cmd_op`=2), with no ACTV.
- R3: A request to a bank with no open row produces ACTV (`cmd_op`=0) in the cycle after acceptance. The column command follows max(`t_rcd`,1) cycles later, and no PRE is issued.
- R4: A request to a different row of an open bank produces PRE (`cmd_op`=5), then ACTV max(`t_rp`,1) cycles later, then the column command max(`t_rcd`,1) cycles after the ACTV.
- R5: A PRE to a bank is never issued earlier than `t_ras_min` cycles after that bank's last ACTV, using the `t_ras_min` value sampled at that ACTV.
- R6: With `policy_mode` other than 0, the column command is READA (`cmd_op`=3) or WRITA (`cmd_op`=4), and the bank is closed afterwards. A later access to the same row therefore starts with ACTV.
- R7: A pulse on `ref_req` while rows are open produces PALL (`cmd_op`=6) and then REF (`cmd_op`=7) max(`t_rp`,1) cycles later, after which all banks are closed. With no bank open, REF alone is issued.
- R8: Only one request is in flight. `req_ready` stays 0 from the acceptance cycle until the cycle after its final column command.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, the command stays valid and `cmd_op` and `cmd_bank` do not change.
- R10: Banks are tracked independently. Opening a row in one bank leaves another bank's open row usable as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| policy_mode | input | 2 | 0 = keep rows open, other = auto-precharge |
| ref_req | input | 1 | Refresh request pulse |
| t_rp | input | 6 | Precharge-to-activate cycles |
| t_rcd | input | 6 | Activate-to-column cycles |
| t_ras_min | input | 6 | Minimum activate-to-precharge cycles |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted by downstream |
| cmd_op | output | 3 | Command code (0 ACTV … 7 REF) |
| cmd_bank | output | 2 | Command bank |
| cmd_row | output | 13 | Row for ACTV and column commands |
| cmd_col | output | 10 | Column for column commands |

## Verification
The bench targets the three row-state cases and checks the exact cycle of every command. A sequencer that misjudged hit versus miss would emit an extra ACTV or skip the PRE. One that miscounted a wait would move the ACTV or the column command by a cycle. A second miss to a bank whose activate used a long `t_ras_min` catches a PRE sent too early. Further cases: an access under auto-precharge followed by one to the same row, two refreshes in a row, and a stalled downstream. These expose a row wrongly kept open after READA, a PALL sent when nothing is open, and a command that changes while `cmd_ready` is low.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_ACTV  = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRIT  = 3'd2,
        CMD_READA = 3'd3,
        CMD_WRITA = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_PALL  = 3'd6,
        CMD_REF   = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_RW,
        ST_PALL,
        ST_REF,
        ST_WAIT
    } st_e;

endpackage

// File: rtl/seq_row_table.sv
`timescale 1ns/1ps
module seq_row_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    localparam int BW = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BW-1:0]    set_bank,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr_en,
    input  logic [BW-1:0]    clr_bank,
    input  logic             clr_all,
    input  logic [BW-1:0]    look_bank,
    output logic             look_open,
    output logic [ROW_W-1:0] look_row,
    output logic             any_open
);

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
    } ent_t;

    ent_t ent_d [BANKS];
    ent_t ent_q [BANKS];
    logic [BANKS-1:0] open_vec;

    always_comb begin
        for (int i = 0; i < BANKS; i++) begin
            ent_d[i] = ent_q[i];
            if (clr_all || (clr_en && clr_bank == BW'(i))) begin
                ent_d[i].valid = 1'b0;
            end
            if (set_en && set_bank == BW'(i)) begin
                ent_d[i].valid = 1'b1;
                ent_d[i].row   = set_row;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < BANKS; i++) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    for (genvar g = 0; g < BANKS; g++) begin : g_open
        assign open_vec[g] = ent_q[g].valid;
    end

    assign look_open = ent_q[look_bank].valid;
    assign look_row  = ent_q[look_bank].row;
    assign any_open  = |open_vec;

endmodule

// File: rtl/seq_ras_guard.sv
`timescale 1ns/1ps
module seq_ras_guard #(
    parameter int BANKS = 4,
    parameter int TW    = 6,
    localparam int BW = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [BW-1:0]    arm_bank,
    input  logic [TW-1:0]    t_ras,
    output logic [BANKS-1:0] ras_ok
);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [TW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (arm && arm_bank == BW'(g)) begin
                cnt_d = t_ras;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign ras_ok[g] = (cnt_q <= TW'(1));
    end

endmodule

// File: rtl/sdram_page_seq.sv
`timescale 1ns/1ps
module sdram_page_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int TW    = 6,
    localparam int BW = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BW-1:0]    req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [1:0]       policy_mode,
    input  logic             ref_req,
    input  logic [TW-1:0]    t_rp,
    input  logic [TW-1:0]    t_rcd,
    input  logic [TW-1:0]    t_ras_min,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [2:0]       cmd_op,
    output logic [BW-1:0]    cmd_bank,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col
);

    typedef struct packed {
        st_e              state;
        st_e              after;
        logic [TW-1:0]    cnt;
        logic             wr;
        logic             autopc;
        logic [BW-1:0]    bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             ref_pend;
    } seq_t;

    seq_t seq_d, seq_q;

    // table and guard hookups
    logic             tbl_set, tbl_clr, tbl_clr_all;
    logic [BW-1:0]    look_bank;
    logic             look_open, any_open;
    logic [ROW_W-1:0] look_row;
    logic [BANKS-1:0] ras_ok;
    logic             fire;
    cmd_e             op;

    // wait launcher
    logic             wait_go;
    logic [TW-1:0]    wait_len;
    st_e              wait_tgt;

    assign look_bank = (seq_q.state == ST_IDLE) ? req_bank : seq_q.bank;
    assign fire      = cmd_valid && cmd_ready;

    seq_row_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (tbl_set),
        .set_bank  (seq_q.bank),
        .set_row   (seq_q.row),
        .clr_en    (tbl_clr),
        .clr_bank  (seq_q.bank),
        .clr_all   (tbl_clr_all),
        .look_bank (look_bank),
        .look_open (look_open),
        .look_row  (look_row),
        .any_open  (any_open)
    );

    seq_ras_guard #(.BANKS(BANKS), .TW(TW)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (tbl_set),
        .arm_bank (seq_q.bank),
        .t_ras    (t_ras_min),
        .ras_ok   (ras_ok)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.ref_pend = seq_q.ref_pend | ref_req;
        req_ready   = (seq_q.state == ST_IDLE) && !seq_q.ref_pend && !ref_req;
        cmd_valid   = 1'b0;
        op          = CMD_ACTV;
        tbl_set     = 1'b0;
        tbl_clr     = 1'b0;
        tbl_clr_all = 1'b0;
        wait_go     = 1'b0;
        wait_len    = '0;
        wait_tgt    = ST_IDLE;

        case (seq_q.state)
            ST_IDLE: begin
                if (seq_q.ref_pend) begin
                    seq_d.state = any_open ? ST_PALL : ST_REF;
                end else if (req_valid && req_ready) begin
                    seq_d.wr     = req_write;
                    seq_d.autopc = (policy_mode != 2'b00);
                    seq_d.bank   = req_bank;
                    seq_d.row    = req_row;
                    seq_d.col    = req_col;
                    if (look_open && look_row == req_row) seq_d.state = ST_RW;
                    else if (look_open)                   seq_d.state = ST_PRE;
                    else                                  seq_d.state = ST_ACT;
                end
            end
            ST_PRE: begin
                cmd_valid = ras_ok[seq_q.bank];
                op        = CMD_PRE;
                if (fire) begin
                    tbl_clr  = 1'b1;
                    wait_go  = 1'b1;
                    wait_len = t_rp;
                    wait_tgt = ST_ACT;
                end
            end
            ST_ACT: begin
                cmd_valid = 1'b1;
                op        = CMD_ACTV;
                if (fire) begin
                    tbl_set  = 1'b1;
                    wait_go  = 1'b1;
                    wait_len = t_rcd;
                    wait_tgt = ST_RW;
                end
            end
            ST_RW: begin
                cmd_valid = 1'b1;
                if (seq_q.autopc) op = seq_q.wr ? CMD_WRITA : CMD_READA;
                else              op = seq_q.wr ? CMD_WRIT  : CMD_READ;
                if (fire) begin
                    if (seq_q.autopc) begin
                        tbl_clr  = 1'b1;
                        wait_go  = 1'b1;
                        wait_len = t_rp;
                        wait_tgt = ST_IDLE;
                    end else begin
                        seq_d.state = ST_IDLE;
                    end
                end
            end
            ST_PALL: begin
                cmd_valid = &ras_ok;
                op        = CMD_PALL;
                if (fire) begin
                    tbl_clr_all = 1'b1;
                    wait_go     = 1'b1;
                    wait_len    = t_rp;
                    wait_tgt    = ST_REF;
                end
            end
            ST_REF: begin
                cmd_valid = 1'b1;
                op        = CMD_REF;
                if (fire) begin
                    seq_d.ref_pend = ref_req;
                    seq_d.state    = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (seq_q.cnt <= TW'(2)) seq_d.state = seq_q.after;
                else                     seq_d.cnt   = seq_q.cnt - 1'b1;
            end
            default: seq_d.state = ST_IDLE;
        endcase

        // a wait of N cycles spaces two commands N cycles apart
        if (wait_go) begin
            if (wait_len <= TW'(1)) begin
                seq_d.state = wait_tgt;
            end else begin
                seq_d.state = ST_WAIT;
                seq_d.after = wait_tgt;
                seq_d.cnt   = wait_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
            seq_q.after <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_op   = op;
    assign cmd_bank = seq_q.bank;
    assign cmd_row  = seq_q.row;
    assign cmd_col  = seq_q.col;

    // column commands only go to a bank whose open row matches
    assert_rw_row_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cmd_op inside {CMD_READ, CMD_WRIT, CMD_READA, CMD_WRITA}))
            |-> (look_open && look_row == cmd_row));

    // activate only reaches a closed bank
    assert_actv_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == CMD_ACTV) |-> !look_open);

    // precharge respects the minimum active time
    assert_pre_after_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == CMD_PRE) |-> ras_ok[cmd_bank]);

    // auto-precharge leaves the bank closed
    assert_autopc_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cmd_op inside {CMD_READA, CMD_WRITA})) |=> !look_open);

    // refresh only with every bank closed
    assert_ref_all_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == CMD_REF) |-> !any_open);

    // no second request while one is in flight
    assert_single_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // a stalled command holds still
    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank)));

endmodule

// File: tb/sdram_page_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_page_seq_tb_top;
    import sdram_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [9:0]  req_col;
    logic [1:0]  policy_mode;
    logic        ref_req;
    logic [5:0]  t_rp, t_rcd, t_ras_min;
    logic        cmd_valid, cmd_ready;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_row;
    logic [9:0]  cmd_col;

    always #10 clk = ~clk;

    sdram_page_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .policy_mode(policy_mode), .ref_req(ref_req),
        .t_rp(t_rp), .t_rcd(t_rcd), .t_ras_min(t_ras_min),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
    );

    int nchk = 0, nerr = 0, cyc = 0, nlog = 0, r8_bad = 0;
    bit busy = 0, done = 0;
    int log_op [256], log_bank [256], log_row [256], log_col [256], log_cyc [256];
    int lastact [4], rasv [4];

    always @(posedge clk) cyc <= cyc + 1;

    // observe away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && req_ready) r8_bad++;
            if (cmd_valid && cmd_ready) begin
                if (nlog < 256) begin
                    log_op[nlog]   = int'(cmd_op);
                    log_bank[nlog] = int'(cmd_bank);
                    log_row[nlog]  = int'(cmd_row);
                    log_col[nlog]  = int'(cmd_col);
                    log_cyc[nlog]  = cyc;
                end
                nlog++;
                if (cmd_op inside {3'd1, 3'd2, 3'd3, 3'd4}) busy = 0;
            end
            if (req_valid && req_ready) busy = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    function automatic int mx1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // kind: 0 hit, 1 closed bank, 2 row miss
    task automatic run_req(input logic [1:0] pol, input logic wr, input logic [1:0] b,
                           input logic [12:0] row, input logic [9:0] col,
                           input int kind, input string tag);
        int start, acc, ncmd, t_first, t_act, t_rw, idx, w, rw_op;
        start = nlog;
        @(posedge clk); #1;
        policy_mode = pol; req_write = wr; req_bank = b; req_row = row; req_col = col;
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        acc = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
        ncmd = kind + 1;
        w = 0;
        while (nlog < start + ncmd && w < 200) begin @(negedge clk); w++; end
        while (!req_ready && w < 400) begin @(negedge clk); w++; end
        repeat (2) @(negedge clk);
        chk(nlog == start + ncmd, tag, "command count", nlog - start, ncmd);
        if (nlog != start + ncmd) return;
        rw_op = (pol == 2'd0) ? (wr ? 2 : 1) : (wr ? 4 : 3);
        t_first = acc + 1;
        idx = start;
        if (kind == 2) begin
            if (lastact[b] + rasv[b] > t_first) t_first = lastact[b] + rasv[b];
            chk(log_op[idx] == 5 && log_bank[idx] == int'(b), tag, "PRE op", log_op[idx], 5);
            chk(log_cyc[idx] == t_first, tag, "PRE cycle", log_cyc[idx], t_first);
            t_act = t_first + mx1(int'(t_rp));
            idx++;
        end else begin
            t_act = t_first;
        end
        if (kind >= 1) begin
            chk(log_op[idx] == 0 && log_row[idx] == int'(row), tag, "ACTV op/row", log_op[idx], 0);
            chk(log_cyc[idx] == t_act, tag, "ACTV cycle", log_cyc[idx], t_act);
            lastact[b] = t_act;
            rasv[b]    = int'(t_ras_min);
            t_rw = t_act + mx1(int'(t_rcd));
            idx++;
        end else begin
            t_rw = t_first;
        end
        chk(log_op[idx] == rw_op && log_bank[idx] == int'(b) && log_col[idx] == int'(col),
            tag, "column op", log_op[idx], rw_op);
        chk(log_cyc[idx] == t_rw, tag, "column cycle", log_cyc[idx], t_rw);
    endtask

    // {policy, write, bank, row, col, kind}
    localparam logic [29:0] VEC [0:11] = '{
        {2'd0, 1'b0, 2'd0, 13'd10, 10'd1,  2'd1},
        {2'd0, 1'b1, 2'd0, 13'd10, 10'd2,  2'd0},
        {2'd0, 1'b0, 2'd1, 13'd20, 10'd3,  2'd1},
        {2'd0, 1'b0, 2'd0, 13'd10, 10'd4,  2'd0},   // R10: bank 0 still open
        {2'd0, 1'b1, 2'd0, 13'd11, 10'd5,  2'd2},
        {2'd0, 1'b0, 2'd1, 13'd21, 10'd6,  2'd2},
        {2'd0, 1'b0, 2'd0, 13'd11, 10'd7,  2'd0},
        {2'd1, 1'b0, 2'd2, 13'd30, 10'd8,  2'd1},
        {2'd1, 1'b1, 2'd2, 13'd30, 10'd9,  2'd1},   // R6: reopened after READA
        {2'd2, 1'b0, 2'd0, 13'd11, 10'd10, 2'd0},
        {2'd0, 1'b0, 2'd0, 13'd11, 10'd11, 2'd1},   // R6: closed by READA
        {2'd0, 1'b1, 2'd3, 13'd5,  10'd12, 2'd1}
    };

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int start, w, op0;
        bit hold_ok;
        string tag;
        rst_n = 0; req_valid = 0; req_write = 0; req_bank = 0; req_row = 0; req_col = 0;
        policy_mode = 0; ref_req = 0; cmd_ready = 1;
        t_rp = 6'd3; t_rcd = 6'd2; t_ras_min = 6'd4;
        for (int i = 0; i < 4; i++) begin lastact[i] = 0; rasv[i] = 0; end
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);

        for (int i = 0; i < 12; i++) begin
            if (i == 3) tag = "R10";
            else if (VEC[i][29:28] != 2'd0 || i == 10) tag = "R6";
            else if (VEC[i][1:0] == 2'd0) tag = "R2";
            else if (VEC[i][1:0] == 2'd1) tag = "R3";
            else tag = "R4";
            run_req(VEC[i][29:28], VEC[i][27], VEC[i][26:25], VEC[i][24:12],
                    VEC[i][11:2], int'(VEC[i][1:0]), tag);
        end

        // R5: long active-time minimum delays the second precharge
        @(posedge clk); #1 t_ras_min = 6'd10;
        run_req(2'd0, 1'b0, 2'd3, 13'd6, 10'd13, 2, "R5");
        run_req(2'd0, 1'b0, 2'd3, 13'd7, 10'd14, 2, "R5");
        @(posedge clk); #1 t_ras_min = 6'd4;

        // R9: downstream stall on a hit to bank 1 row 21
        start = nlog;
        @(posedge clk); #1;
        cmd_ready = 0; policy_mode = 0; req_write = 0; req_bank = 2'd1;
        req_row = 13'd21; req_col = 10'd15; req_valid = 1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1 req_valid = 0;
        @(negedge clk);
        op0 = int'(cmd_op);
        hold_ok = cmd_valid;
        repeat (3) begin
            @(negedge clk);
            if (!cmd_valid || int'(cmd_op) != op0) hold_ok = 0;
        end
        chk(hold_ok, "R9", "command held while stalled", int'(hold_ok), 1);
        @(posedge clk); #1 cmd_ready = 1;
        w = 0;
        while (!req_ready && w < 100) begin @(negedge clk); w++; end
        chk(nlog == start + 1 && log_op[start] == 1, "R9", "stalled READ delivered",
            log_op[start], 1);

        // R7: refresh with open banks, then with none open
        start = nlog;
        @(posedge clk); #1 ref_req = 1;
        @(posedge clk); #1 ref_req = 0;
        w = 0;
        while (nlog < start + 2 && w < 100) begin @(negedge clk); w++; end
        chk(log_op[start] == 6, "R7", "PALL first", log_op[start], 6);
        chk(log_op[start+1] == 7, "R7", "REF second", log_op[start+1], 7);
        chk(log_cyc[start+1] - log_cyc[start] == 3, "R7", "PALL to REF spacing",
            log_cyc[start+1] - log_cyc[start], 3);
        repeat (3) @(negedge clk);
        start = nlog;
        @(posedge clk); #1 ref_req = 1;
        @(posedge clk); #1 ref_req = 0;
        repeat (10) @(negedge clk);
        chk(nlog == start + 1 && log_op[start] == 7, "R7", "REF alone when closed",
            nlog - start, 1);
        run_req(2'd0, 1'b0, 2'd0, 13'd11, 10'd16, 1, "R7");

        chk(r8_bad == 0, "R8", "req_ready low while busy", r8_bad, 0);
        finish_up();
    end

endmodule